// File: doc/BRIEF.md
# Audio Clock Strobe Generator

This block derives the three clocks of a serial audio link from one internal clock that the system runs at either 512 or 384 times the sample rate fs. It produces an oversampled master clock as a one-cycle strobe, a bit clock and a left/right frame clock as levels, and a strobe that marks the first internal cycle of every frame. Every output is registered in the internal clock domain, so downstream logic uses them as clock enables and no gated or derived clock exists.

The master clock period is the internal clock period multiplied by 2 to the power of a 3-bit divide field. On the 512 base this yields 512, 256, 128, 64 or 32 times fs; on the 384 base it yields 384, 192, 96 or 48 times fs. The frame holds either 32 bit clocks (short words) or 48 bit clocks (20- and 24-bit words). A run input starts and stops all generation. A settings combination that cannot be produced raises an error flag and keeps every clock output low. The settings must not change while run is high. There is no data stream at this block's edge: all pins are plain control and status levels.

Top module: `audio_clkgen`

## Requirements
- R1: While rst_n is low, and on the first falling edge after it rises, mclk_stb, bclk, lrclk, frame_stb and cfg_err are all 0.
- R2: With base_lo=0 (512 internal cycles per frame) and div_sel=d for d from 0 to 4, mclk_stb pulses on every internal cycle whose frame index is a multiple of 2^d, which gives 512/2^d pulses per frame. With d=0 it stays high.
- R3: With base_lo=1 (384 internal cycles per frame) and div_sel=d for d from 0 to 3, mclk_stb pulses on every frame index that is a multiple of 2^d, which gives 384/2^d pulses per frame.
- R4: With wide_frame=0 the frame holds 32 bit clocks. The bit period P is the frame length divided by 32 (16 cycles on the 512 base, 12 on the 384 base). bclk is low for the first P/2 cycles of each bit and high for the rest.
- R5: With wide_frame=1 and base_lo=1 the frame holds 48 bit clocks of 8 internal cycles each, with the same low-then-high shape as R4.
- R6: lrclk is low during the first half of the bits of a frame and high during the second half. frame_stb is high only on frame index 0.
- R7: The first internal clock edge that samples run=1 produces the outputs of frame index 0. The index then advances by one per cycle and wraps at the frame length.
- R8: The first edge that samples run=0 drives mclk_stb, bclk, lrclk and frame_stb to 0. They stay at 0 while run is low. The next run restarts at frame index 0.
- R9: cfg_err goes high one edge after div_sel is 5, 6 or 7, or div_sel is 4 with base_lo=1, or wide_frame=1 with base_lo=0. While cfg_err is high, all clock outputs stay at 0 even if run is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at 512·fs or 384·fs |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables clock generation |
| base_lo | input | 1 | 0: 512-cycle frame, 1: 384-cycle frame |
| div_sel | input | 3 | Master clock period is 2^div_sel internal cycles |
| wide_frame | input | 1 | 0: 32 bit clocks per frame, 1: 48 |
| mclk_stb | output | 1 | One-cycle master clock enable strobe |
| bclk | output | 1 | Bit clock level |
| lrclk | output | 1 | Left/right frame clock level |
| frame_stb | output | 1 | High on the first cycle of each frame |
| cfg_err | output | 1 | Settings combination cannot be generated |

## Verification
Each output is one register after the phase counters. An edge that samples run=1 therefore shows frame index 0 at the falling edge that follows it, and frame index k at the k-th falling edge after that. The bench changes inputs only on falling edges and samples on the next falling edge. It computes the expected four-bit clock vector from the index alone, over two full frames for each legal setting. cfg_err is due one edge after a settings change, and the checks on it sample after that edge. The run-low checks sample at the first falling edge after the dropping edge.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int BASE_HI = 512;
  localparam int BASE_LO = 384;
  localparam int BITS_N  = 32;
  localparam int BITS_W  = 48;
  localparam int DIV_W   = 3;
  localparam int CYC_W   = $clog2(BASE_HI);
  localparam int BCNT_W  = $clog2(BASE_HI / BITS_N);
  localparam int BIDX_W  = $clog2(BITS_W);

  typedef struct packed {
    logic [CYC_W-1:0]  frame_last;
    logic [BCNT_W-1:0] bit_last;
    logic [BCNT_W-1:0] bit_half;
    logic [BIDX_W-1:0] bits_last;
    logic [BIDX_W-1:0] bits_half;
    logic [CYC_W-1:0]  mclk_mask;
    logic              bad;
  } acg_cfg_t;
endpackage

// File: rtl/acg_cfg_decode.sv
module acg_cfg_decode
  import acg_pkg::*;
#(
  parameter int MAX_DIV_HI = 4,
  parameter int MAX_DIV_LO = 3
) (
  input  logic             base_lo,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             wide,
  output acg_cfg_t         cfg
);
  localparam bit HI_WIDE_OK = (BASE_HI % BITS_W) == 0;
  localparam bit LO_WIDE_OK = (BASE_LO % BITS_W) == 0;
  localparam int PER_HI_N   = BASE_HI / BITS_N;
  localparam int PER_LO_N   = BASE_LO / BITS_N;
  localparam int PER_HI_W   = BASE_HI / BITS_W;
  localparam int PER_LO_W   = BASE_LO / BITS_W;

  int   per;
  int   nbits;
  logic div_ok;
  logic fmt_ok;

  always_comb begin
    if (base_lo) div_ok = (int'(div_sel) <= MAX_DIV_LO);
    else         div_ok = (int'(div_sel) <= MAX_DIV_HI);
    fmt_ok = !wide || (base_lo ? LO_WIDE_OK : HI_WIDE_OK);
    case ({base_lo, wide})
      2'b00:   per = PER_HI_N;
      2'b01:   per = PER_HI_W;
      2'b10:   per = PER_LO_N;
      default: per = PER_LO_W;
    endcase
    nbits = wide ? BITS_W : BITS_N;
  end

  always_comb begin
    cfg            = '0;
    cfg.frame_last = base_lo ? CYC_W'(BASE_LO - 1) : CYC_W'(BASE_HI - 1);
    cfg.bit_last   = BCNT_W'(per - 1);
    cfg.bit_half   = BCNT_W'(per / 2);
    cfg.bits_last  = BIDX_W'(nbits - 1);
    cfg.bits_half  = BIDX_W'(nbits / 2);
    for (int k = 0; k < CYC_W; k++) begin
      cfg.mclk_mask[k] = (k < int'(div_sel));
    end
    cfg.bad = !(div_ok && fmt_ok);
  end
endmodule

// File: rtl/acg_phase_counter.sv
module acg_phase_counter
  import acg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  acg_cfg_t          cfg,
  output logic [CYC_W-1:0]  cyc,
  output logic [BCNT_W-1:0] bcnt,
  output logic [BIDX_W-1:0] bidx
);
  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      cyc  <= '0;
      bcnt <= '0;
      bidx <= '0;
    end else begin
      cyc <= (cyc == cfg.frame_last) ? '0 : cyc + 1'b1;
      if (bcnt == cfg.bit_last) begin
        bcnt <= '0;
        bidx <= (bidx == cfg.bits_last) ? '0 : bidx + 1'b1;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/acg_clk_out.sv
module acg_clk_out
  import acg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  acg_cfg_t          cfg,
  input  logic [CYC_W-1:0]  cyc,
  input  logic [BCNT_W-1:0] bcnt,
  input  logic [BIDX_W-1:0] bidx,
  output logic              mclk_stb,
  output logic              bclk,
  output logic              lrclk,
  output logic              frame_stb,
  output logic              cfg_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mclk_stb  <= 1'b0;
      bclk      <= 1'b0;
      lrclk     <= 1'b0;
      frame_stb <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      mclk_stb  <= active && ((cyc & cfg.mclk_mask) == '0);
      bclk      <= active && (bcnt >= cfg.bit_half);
      lrclk     <= active && (bidx >= cfg.bits_half);
      frame_stb <= active && (cyc == '0);
      cfg_err   <= cfg.bad;
    end
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import acg_pkg::*;
#(
  parameter int MAX_DIV_HI = 4,
  parameter int MAX_DIV_LO = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             base_lo,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             wide_frame,
  output logic             mclk_stb,
  output logic             bclk,
  output logic             lrclk,
  output logic             frame_stb,
  output logic             cfg_err
);
  acg_cfg_t          cfg;
  logic              active;
  logic [CYC_W-1:0]  cyc;
  logic [BCNT_W-1:0] bcnt;
  logic [BIDX_W-1:0] bidx;

  acg_cfg_decode #(.MAX_DIV_HI(MAX_DIV_HI), .MAX_DIV_LO(MAX_DIV_LO)) u_dec (
    .base_lo (base_lo),
    .div_sel (div_sel),
    .wide    (wide_frame),
    .cfg     (cfg)
  );

  assign active = run && !cfg.bad;

  acg_phase_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .cfg    (cfg),
    .cyc    (cyc),
    .bcnt   (bcnt),
    .bidx   (bidx)
  );

  acg_clk_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .cfg       (cfg),
    .cyc       (cyc),
    .bcnt      (bcnt),
    .bidx      (bidx),
    .mclk_stb  (mclk_stb),
    .bclk      (bclk),
    .lrclk     (lrclk),
    .frame_stb (frame_stb),
    .cfg_err   (cfg_err)
  );
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic mclk_stb,
  input logic bclk,
  input logic lrclk,
  input logic frame_stb,
  input logic cfg_err
);
  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !(mclk_stb || bclk || lrclk || frame_stb));

  a_r8_run_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !(mclk_stb || bclk || lrclk || frame_stb));

  a_r6_frame_left: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> !lrclk);

  a_r2_frame_on_mclk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> mclk_stb);

  a_r4_bit_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> !bclk);

  a_r7_frame_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb);
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .mclk_stb  (mclk_stb),
  .bclk      (bclk),
  .lrclk     (lrclk),
  .frame_stb (frame_stb),
  .cfg_err   (cfg_err)
);

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       base_lo = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic       wide_frame = 1'b0;
  logic       mclk_stb, bclk, lrclk, frame_stb, cfg_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  audio_clkgen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .base_lo    (base_lo),
    .div_sel    (div_sel),
    .wide_frame (wide_frame),
    .mclk_stb   (mclk_stb),
    .bclk       (bclk),
    .lrclk      (lrclk),
    .frame_stb  (frame_stb),
    .cfg_err    (cfg_err)
  );

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {mclk,bclk,lr,frame,err} actual %b expected %b at %0t",
               req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] outs();
    return {mclk_stb, bclk, lrclk, frame_stb, cfg_err};
  endfunction

  function automatic logic [4:0] expect_at(bit blo, int d, bit w, int i);
    int fl = blo ? 384 : 512;
    int nb = w ? 48 : 32;
    int p  = fl / nb;
    int ix = i % fl;
    logic m  = (ix % (1 << d)) == 0;
    logic b  = (ix % p) >= (p / 2);
    logic lr = (ix / p) >= (nb / 2);
    logic f  = (ix == 0);
    return {m, b, lr, f, 1'b0};
  endfunction

  task automatic set_cfg(bit blo, int d, bit w);
    @(negedge clk);
    run = 1'b0; base_lo = blo; div_sel = 3'(d); wide_frame = w;
    @(negedge clk);
  endtask

  // R1: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", outs(), 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", outs(), 5'b0);
  endtask

  // R2..R7: legal setting over two frames from a fresh start
  task automatic t_legal(bit blo, int d, bit w, string req);
    int fl = blo ? 384 : 512;
    set_cfg(blo, d, w);
    check({req, " R9 err clear"}, outs(), 5'b0);
    run = 1'b1;
    for (int i = 0; i < 2 * fl; i++) begin
      @(negedge clk);
      check({req, " R6 R7"}, outs(), expect_at(blo, d, w, i));
    end
    run = 1'b0;
    @(negedge clk);
  endtask

  // R9: impossible setting keeps clocks low with run high
  task automatic t_invalid(bit blo, int d, bit w);
    set_cfg(blo, d, w);
    run = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R9 invalid quiet", outs(), 5'b00001);
    end
    run = 1'b0;
  endtask

  // R8: stop mid-frame, stay low, restart at index 0
  task automatic t_run_gate();
    set_cfg(1'b0, 1, 1'b0);
    run = 1'b1;
    repeat (300) @(negedge clk);
    run = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R8 stopped", outs(), 5'b0);
    end
    run = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      check("R8 restart at index 0", outs(), expect_at(1'b0, 1, 1'b0, i));
    end
    run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    for (int d = 0; d <= 4; d++) t_legal(1'b0, d, 1'b0, "R2 R4 base512");
    for (int d = 0; d <= 3; d++) t_legal(1'b1, d, 1'b0, "R3 R4 base384");
    for (int d = 0; d <= 3; d++) t_legal(1'b1, d, 1'b1, "R3 R5 wide384");
    t_invalid(1'b0, 5, 1'b0);
    t_invalid(1'b0, 7, 1'b0);
    t_invalid(1'b1, 4, 1'b0);
    t_invalid(1'b0, 2, 1'b1);
    t_run_gate();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule